// File: doc/BRIEF.md
# Lockable I/O Chip-Select Decoder

This block keeps a programmable 16-bit I/O base address for each of several external chip selects and pulls the matching active-low select when a host I/O cycle lands inside that select's window. Software reaches the settings through a byte-wide indexed register port. Every select owns two neighbouring indices. The first holds the upper address byte. The second holds the lower address bits, a disable flag and a lock flag.

Once set, the lock freezes both registers of its select until the next hardware reset. A synchronous soft reset wipes the address and disable fields but keeps every lock. A static per-select input chooses the window size. One setting compares address bits [15:2] for a 4-byte window. The other compares bits [15:4] for a 16-byte window.

Top module: `iocs_decoder`

## Requirements
- R1: Select k (counting from 0) has its upper-address register at index 0x62+2k and its lower register at 0x63+2k. A read of either returns the stored byte whether or not the select is locked. The upper register holds address[15:8].
- R2: Lower register layout: bit 0 is the disable flag (1 = select never asserts, 0 = enabled), bit 1 is the lock flag, and bits [7:2] hold address[7:2].
- R3: While a select's lock flag is 1, writes to both of its registers, including the lock flag itself, have no effect.
- R4: Writing 0 to a set lock flag does not clear it, and neither does soft reset. Only the asynchronous hardware reset clears it.
- R5: A soft-reset cycle clears the upper register, the lower address bits and the disable flag of every select, including locked ones. It overrides a write in the same cycle.
- R6: After hardware reset every register reads 0x00, and every cs_n output is 1 while io_valid is 0.
- R7: With cs_mode[k]=0, select k matches when io_addr[15:2] equals its base bits [15:2] (4-byte window).
- R8: With cs_mode[k]=1, select k matches when io_addr[15:4] equals base bits [15:4] (16-byte window). Lower-register bits [3:2] read back as written but take no part in the match.
- R9: cs_n[k] is 0 only when io_valid=1, select k is enabled and its window matches. It is combinational from io_addr and io_valid, and a register write takes effect from the cycle after the write.
- R10: Indices outside the implemented range read 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| soft_rst | input | 1 | Synchronous soft reset, one cycle high |
| reg_idx | input | 8 | Register index |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe, applied at the clock edge |
| reg_rdata | output | 8 | Read data for reg_idx, combinational |
| cs_mode | input | NUM_CS | Per-select window size: 0 = 4 bytes, 1 = 16 bytes |
| io_addr | input | 16 | Host I/O address |
| io_valid | input | 1 | Host I/O cycle in progress |
| cs_n | output | NUM_CS | Active-low chip selects |

## Verification
The hardest state to reach is a select that is locked and then goes through a soft reset. In that state the address fields are zero but the lock is still set, and only further write attempts show that the lock survived. The stimulus programs and locks select 0 and tries several overwrites. It then pulses soft reset and checks that the lower register reads exactly the lock bit and that a new upper-byte write still bounces. Finally it applies a hardware reset and checks that the same write now lands.

// File: rtl/iocs_pkg.sv
package iocs_pkg;
  parameter int IDX_W  = 8;
  parameter int DATA_W = 8;
  parameter int ADDR_W = 16;

  // Bit positions inside the lower register
  localparam int DIS_BIT  = 0;
  localparam int LOCK_BIT = 1;
  localparam int LOW_LSB  = 2;
endpackage

// File: rtl/iocs_slot.sv
module iocs_slot
  import iocs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [DATA_W-1:0] wdata,
  input  logic              mode16,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_valid,
  output logic [DATA_W-1:0] hi_q,
  output logic [DATA_W-1:0] lo_rd,
  output logic              cs_n
);
  localparam int LOW_W = DATA_W - LOW_LSB;

  logic [LOW_W-1:0]  low_q, low_d;
  logic [DATA_W-1:0] hi_d;
  logic              lock_q, lock_d, dis_q, dis_d;
  logic              fld_en, lock_en;
  logic [LOW_W-1:0]  cmp_mask;
  logic              hit;

  // Next state for address/disable fields and lock
  always_comb begin
    hi_d   = hi_q;
    low_d  = low_q;
    dis_d  = dis_q;
    lock_d = lock_q;
    if (soft_rst) begin
      hi_d  = '0;
      low_d = '0;
      dis_d = 1'b0;
    end else if (!lock_q) begin
      if (wr_hi) hi_d = wdata;
      if (wr_lo) begin
        low_d  = wdata[DATA_W-1:LOW_LSB];
        dis_d  = wdata[DIS_BIT];
        lock_d = wdata[LOCK_BIT];
      end
    end
  end

  assign fld_en  = soft_rst | (~lock_q & (wr_hi | wr_lo));
  assign lock_en = ~soft_rst & ~lock_q & wr_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      low_q <= '0;
      dis_q <= 1'b0;
    end else if (fld_en) begin
      hi_q  <= hi_d;
      low_q <= low_d;
      dis_q <= dis_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lock_q <= 1'b0;
    else if (lock_en) lock_q <= lock_d;
  end

  assign lo_rd = {low_q, lock_q, dis_q};

  // Window comparison: 16-byte mode drops the two lowest stored bits
  always_comb begin
    cmp_mask = '1;
    if (mode16) cmp_mask[1:0] = 2'b00;
  end

  assign hit  = (io_addr[ADDR_W-1:DATA_W] == hi_q) &&
                (((io_addr[DATA_W-1:LOW_LSB] ^ low_q) & cmp_mask) == '0);
  assign cs_n = ~(io_valid & ~dis_q & hit);

  // R3
  lock_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !soft_rst) |=> ($stable(hi_q) && $stable(lo_rd)));
  // R4
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
  // R5
  soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (hi_q == '0 && lo_rd[DATA_W-1:LOW_LSB] == '0 && !lo_rd[DIS_BIT]));
  // R1
  hi_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && !lock_q && !soft_rst) |=> (hi_q == $past(wdata)));
  // R9
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_rd[DIS_BIT] |-> cs_n);
endmodule

// File: rtl/iocs_rdmux.sv
module iocs_rdmux
  import iocs_pkg::*;
#(
  parameter int              NUM_CS   = 3,
  parameter logic [IDX_W-1:0] BASE_IDX = 8'h62
)(
  input  logic [IDX_W-1:0]              idx,
  input  logic [NUM_CS-1:0][DATA_W-1:0] hi_all,
  input  logic [NUM_CS-1:0][DATA_W-1:0] lo_all,
  output logic [DATA_W-1:0]             rdata
);
  logic [IDX_W-1:0] off;
  logic             in_range;

  assign off      = idx - BASE_IDX;
  assign in_range = (idx >= BASE_IDX) && (off < IDX_W'(2 * NUM_CS));

  always_comb begin
    rdata = '0;
    for (int k = 0; k < NUM_CS; k++) begin
      if (in_range && (off[IDX_W-1:1] == (IDX_W-1)'(k)))
        rdata = off[0] ? lo_all[k] : hi_all[k];
    end
  end
endmodule

// File: rtl/iocs_decoder.sv
module iocs_decoder
  import iocs_pkg::*;
#(
  parameter int               NUM_CS   = 3,
  parameter logic [IDX_W-1:0] BASE_IDX = 8'h62
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_we,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NUM_CS-1:0] cs_mode,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_valid,
  output logic [NUM_CS-1:0] cs_n
);
  logic [NUM_CS-1:0][DATA_W-1:0] hi_all, lo_all;
  logic [NUM_CS-1:0]             wr_hi, wr_lo;

  for (genvar k = 0; k < NUM_CS; k++) begin : g_slot
    localparam logic [IDX_W-1:0] HI_IDX = IDX_W'(BASE_IDX + 2 * k);
    localparam logic [IDX_W-1:0] LO_IDX = IDX_W'(BASE_IDX + 2 * k + 1);

    assign wr_hi[k] = reg_we && (reg_idx == HI_IDX);
    assign wr_lo[k] = reg_we && (reg_idx == LO_IDX);

    iocs_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_rst (soft_rst),
      .wr_hi    (wr_hi[k]),
      .wr_lo    (wr_lo[k]),
      .wdata    (reg_wdata),
      .mode16   (cs_mode[k]),
      .io_addr  (io_addr),
      .io_valid (io_valid),
      .hi_q     (hi_all[k]),
      .lo_rd    (lo_all[k]),
      .cs_n     (cs_n[k])
    );
  end

  iocs_rdmux #(.NUM_CS(NUM_CS), .BASE_IDX(BASE_IDX)) u_rdmux (
    .idx    (reg_idx),
    .hi_all (hi_all),
    .lo_all (lo_all),
    .rdata  (reg_rdata)
  );

  // R10
  stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && (wr_hi == '0) && (wr_lo == '0) && !soft_rst)
      |=> ($stable(hi_all) && $stable(lo_all)));
  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !io_valid |-> (cs_n == '1));
endmodule

// File: tb/iocs_decoder_test.sv
`timescale 1ns/1ps
module iocs_decoder_test;
  localparam int NCS = 3;

  logic clk = 1'b0;
  logic rst_n, soft_rst, reg_we, io_valid;
  logic [7:0]  reg_idx, reg_wdata, reg_rdata;
  logic [15:0] io_addr;
  logic [NCS-1:0] cs_mode, cs_n;

  iocs_decoder uut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata),
    .cs_mode(cs_mode), .io_addr(io_addr), .io_valid(io_valid), .cs_n(cs_n)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    bit         is_cs;
    logic [7:0] exp;
    string      req;
  } item_t;

  item_t sb[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // Monitor: compare at falling edge, away from the active edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it  = sb.pop_front();
      act = it.is_cs ? {5'b0, cs_n} : reg_rdata;
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %02h expected %02h", it.req, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [7:0] idx, input logic [7:0] d);
    @(posedge clk); #1;
    reg_idx = idx; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic chk_rd(input logic [7:0] idx, input logic [7:0] e, input string r);
    @(posedge clk); #1;
    reg_idx = idx; reg_we = 1'b0;
    sb.push_back('{is_cs: 1'b0, exp: e, req: r});
  endtask

  task automatic chk_cs(input logic [15:0] a, input logic v, input logic [2:0] e,
                        input string r);
    @(posedge clk); #1;
    io_addr = a; io_valid = v;
    sb.push_back('{is_cs: 1'b1, exp: {5'b0, e}, req: r});
  endtask

  task automatic pulse_soft();
    @(posedge clk); #1; soft_rst = 1'b1;
    @(posedge clk); #1; soft_rst = 1'b0;
  endtask

  task automatic hw_reset();
    @(posedge clk); #1; rst_n = 1'b0;
    @(posedge clk); #1; rst_n = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; soft_rst = 1'b0; reg_we = 1'b0; reg_idx = 8'h00;
    reg_wdata = 8'h00; io_addr = 16'h0000; io_valid = 1'b0;
    cs_mode = 3'b010; // select 1 uses the 16-byte window
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R6 reset state
    for (int i = 0; i < 6; i++) chk_rd(8'h62 + 8'(i), 8'h00, "R6");
    chk_cs(16'h0000, 1'b0, 3'b111, "R6");

    // R1 / R7 select 0 at 0x03A0, 4-byte window
    wr(8'h62, 8'h03); wr(8'h63, 8'hA0);
    chk_rd(8'h62, 8'h03, "R1");
    chk_rd(8'h63, 8'hA0, "R1");
    chk_cs(16'h03A3, 1'b1, 3'b110, "R7");
    chk_cs(16'h03A4, 1'b1, 3'b111, "R7");
    chk_cs(16'h039F, 1'b1, 3'b111, "R7");
    chk_cs(16'h03A0, 1'b0, 3'b111, "R9");

    // R8 select 1 at 0x125C, reserved bits set, 16-byte window
    wr(8'h64, 8'h12); wr(8'h65, 8'h5C);
    chk_rd(8'h65, 8'h5C, "R8");
    chk_cs(16'h1250, 1'b1, 3'b101, "R8");
    chk_cs(16'h125F, 1'b1, 3'b101, "R8");
    chk_cs(16'h1260, 1'b1, 3'b111, "R8");

    // R2 disable flag
    wr(8'h63, 8'hA1);
    chk_cs(16'h03A0, 1'b1, 3'b111, "R2");
    wr(8'h63, 8'hA0);
    chk_cs(16'h03A1, 1'b1, 3'b110, "R2");

    // R9 write takes effect the next cycle: select 2 at 0x2000
    wr(8'h66, 8'h20);
    chk_cs(16'h2001, 1'b1, 3'b011, "R9");

    // R2 / R3 / R4 lock select 0
    wr(8'h63, 8'hA2);
    chk_rd(8'h63, 8'hA2, "R2");
    wr(8'h62, 8'h55);
    chk_rd(8'h62, 8'h03, "R3");
    wr(8'h63, 8'h01);
    chk_rd(8'h63, 8'hA2, "R4");
    chk_cs(16'h03A2, 1'b1, 3'b110, "R3");

    // R10 unimplemented indices
    wr(8'h70, 8'hFF); wr(8'h61, 8'hFF);
    chk_rd(8'h70, 8'h00, "R10");
    chk_rd(8'h61, 8'h00, "R10");
    chk_rd(8'h62, 8'h03, "R10");
    chk_rd(8'h66, 8'h20, "R10");

    // R5 soft reset clears fields, lock survives
    pulse_soft();
    chk_rd(8'h62, 8'h00, "R5");
    chk_rd(8'h63, 8'h02, "R5");
    chk_rd(8'h64, 8'h00, "R5");
    chk_rd(8'h65, 8'h00, "R5");
    chk_rd(8'h66, 8'h00, "R5");
    chk_cs(16'h0001, 1'b1, 3'b000, "R5");
    wr(8'h62, 8'h44);
    chk_rd(8'h62, 8'h00, "R4");

    // R4 hardware reset releases the lock
    hw_reset();
    chk_rd(8'h63, 8'h00, "R4");
    wr(8'h62, 8'h44);
    chk_rd(8'h62, 8'h44, "R4");

    @(posedge clk); @(negedge clk); #1;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(100000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule